// File: doc/BRIEF.md
# Error-Record Store Register Front-End

This block puts a sixteen-byte, byte-wide I/O window between host firmware and a persistent error-record storage engine. Firmware selects an operation code, sets a record offset, and points a 32-bit register at an eight-byte mailbox in system memory. A write to the top byte of the launch register starts the selected operation. The block reports busy and the last completion status through a status port. Record identifiers are 64 bits wide, which is wider than any port, so the block carries them through the memory mailbox. It uses a memory-master port that moves 32-bit beats, low word first.

Reading the identifier port starts an identifier walk. The block fetches the current identifier from the mailbox and asks the engine for its successor. It then writes the engine's answer back to the mailbox. The engine decides whether that answer is the next identifier, the first identifier, or all ones. The launch port always reads back as all ones, so firmware read masks can produce any constant. The storage engine sits behind a level request and a one-cycle done pulse.

Top module: `errstore_regfront`

## Requirements
- R1: After reset, the operation code, record offset, mailbox pointer, busy flag and status are zero, and neither `mem_req` nor `eng_req` is asserted.
- R2: Port 0x0 stores `io_wdata[1:0]` as the operation code (0 create, 1 fetch, 2 erase, 3 no-op) and reads back `{6'b0, code}`.
- R3: Ports 0x4 to 0x7 form a 32-bit read/write record offset, little-endian: port 0x4 holds bits 7:0 and port 0x7 holds bits 31:24.
- R4: Ports 0x8 to 0xB read back the `rec_count` input, little-endian. Writes to them set the 32-bit mailbox pointer, which then appears on `mem_addr` for the low word and on pointer+4 for the high word.
- R5: Ports 0xC to 0xF read 0xFF. Ports 0x2 and 0x3 read 0x00, and writes to ports 0x1 to 0x3 have no effect.
- R6: A write to port 0xF while idle launches the operation, using `{byte 0xF, byte 0xE, byte 0xD, byte 0xC}` as the launch value. For code 0, the engine request carries `eng_op`=0, the launch value as base and the record offset, and no memory access is made.
- R7: For code 1 or 2, the block reads the mailbox low word at the pointer and then the high word at pointer+4, before it requests the engine with the assembled identifier. Code 1 (`eng_op`=1) passes the launch value as base. Code 2 (`eng_op`=2) passes base 0.
- R8: A launch with code 3 sets no busy flag, makes no memory access and makes no engine request.
- R9: A read of port 0x2 while idle performs an identifier walk. It makes two mailbox reads, then an engine request with `eng_op`=4 and the fetched identifier. It then writes `eng_rid` back, low word to the pointer first and then high word to pointer+4.
- R10: Port 0x1 reads `{busy, status[6:0]}`. Busy is set from the edge that accepts a launch or walk until the edge that ends it: the engine done edge for codes 0 to 2, or the last write-back beat for a walk. Status takes `eng_status` only at an engine done edge.
- R11: Launches and port 0x2 reads that arrive while busy are ignored, including in the cycle where `eng_done` is high.
- R12: The engine request fields stay fixed for the whole operation, even if firmware rewrites the offset or the code while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port offset within the window |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe (side effect on port 0x2) |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational on io_addr |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Beat write data |
| mem_ack | input | 1 | Beat completes on this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| eng_req | output | 1 | Engine request, held until eng_done |
| eng_op | output | 3 | 0 create, 1 fetch, 2 erase, 4 successor lookup |
| eng_base | output | 32 | Buffer base |
| eng_offset | output | 32 | Record offset |
| eng_id | output | 64 | Record identifier |
| eng_done | input | 1 | Engine finished, one cycle |
| eng_status | input | 7 | Completion code |
| eng_rid | input | 64 | Identifier to write back after a walk |
| rec_count | input | 32 | Number of stored records |

## Verification
Engine completion and a fresh launch or walk can land on the same clock edge. The bench provokes this by polling until `eng_done` is high, then driving a launch write to port 0xF in that same cycle. It judges the result by the absence of a second engine request and by busy falling on that edge. A second overlap comes from rewriting the offset and the code while an operation is in flight. That case is judged by the fields the engine captures at done. A behavioural model predicts the port read byte on every cycle, so busy and status timing are checked continuously.

// File: rtl/errstore_pkg.sv
package errstore_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 2 * WORD_W;
    localparam int STAT_W = 7;
    localparam int IOA_W  = 4;
    localparam int STG_W  = WORD_W - 8;

    typedef enum logic [1:0] {
        OPC_CREATE = 2'd0,
        OPC_FETCH  = 2'd1,
        OPC_ERASE  = 2'd2,
        OPC_NOP    = 2'd3
    } opc_e;

    typedef enum logic [2:0] {
        ENG_CREATE = 3'd0,
        ENG_FETCH  = 3'd1,
        ENG_ERASE  = 3'd2,
        ENG_NEXTID = 3'd4
    } eng_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_LO, S_RD_HI, S_ENG, S_WR_LO, S_WR_HI
    } seq_st_e;
endpackage

// File: rtl/errstore_regfile.sv
module errstore_regfile
    import errstore_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IOA_W-1:0]   io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    input  logic               busy,
    input  logic [STAT_W-1:0]  status,
    input  logic [WORD_W-1:0]  rec_count,
    output opc_e               op,
    output logic [WORD_W-1:0]  offset,
    output logic [WORD_W-1:0]  mbox_ptr,
    output logic               trig,
    output logic [WORD_W-1:0]  trig_val,
    output logic               walk
);
    typedef struct packed {
        opc_e              op;
        logic [WORD_W-1:0] off;
        logic [WORD_W-1:0] ptr;
        logic [STG_W-1:0]  stage;
    } regs_t;

    regs_t r_q, r_d;
    logic [1:0] bsel;

    assign bsel = io_addr[1:0];

    always_comb begin
        r_d = r_q;
        if (io_wr) begin
            if (io_addr == 4'h0)
                r_d.op = opc_e'(io_wdata[1:0]);
            if (io_addr[3:2] == 2'd1)
                r_d.off[8*bsel +: 8] = io_wdata;
            if (io_addr[3:2] == 2'd2)
                r_d.ptr[8*bsel +: 8] = io_wdata;
            if (io_addr[3:2] == 2'd3 && bsel != 2'd3)
                r_d.stage[8*bsel +: 8] = io_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        io_rdata = 8'h00;
        unique case (io_addr[3:2])
            2'd0: begin
                if (io_addr == 4'h0) io_rdata = {6'b0, r_q.op};
                if (io_addr == 4'h1) io_rdata = {busy, status};
            end
            2'd1: io_rdata = r_q.off[8*bsel +: 8];
            2'd2: io_rdata = rec_count[8*bsel +: 8];
            default: io_rdata = 8'hFF;
        endcase
    end

    assign op       = r_q.op;
    assign offset   = r_q.off;
    assign mbox_ptr = r_q.ptr;
    assign trig     = io_wr && (io_addr == 4'hF);
    assign trig_val = {io_wdata, r_q.stage};
    assign walk     = io_rd && (io_addr == 4'h2);
endmodule

// File: rtl/errstore_seq.sv
module errstore_seq
    import errstore_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  opc_e               op,
    input  logic [WORD_W-1:0]  offset,
    input  logic [WORD_W-1:0]  mbox_ptr,
    input  logic               trig,
    input  logic [WORD_W-1:0]  trig_val,
    input  logic               walk,
    output logic               busy,
    output logic [STAT_W-1:0]  status,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               eng_req,
    output logic [2:0]         eng_op,
    output logic [WORD_W-1:0]  eng_base,
    output logic [WORD_W-1:0]  eng_offset,
    output logic [ID_W-1:0]    eng_id,
    input  logic               eng_done,
    input  logic [STAT_W-1:0]  eng_status,
    input  logic [ID_W-1:0]    eng_rid
);
    typedef struct packed {
        seq_st_e           st;
        eng_op_e           kind;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] off;
        logic [WORD_W-1:0] ptr;
        logic [ID_W-1:0]   id;
        logic [STAT_W-1:0] stat;
    } seq_t;

    seq_t s_q, s_d;
    logic [WORD_W-1:0] ptr_hi;

    assign ptr_hi = WORD_W'(s_q.ptr + WORD_W'(4));

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = s_q.ptr;
        mem_wdata = s_q.id[WORD_W-1:0];
        eng_req   = 1'b0;
        unique case (s_q.st)
            S_IDLE: begin
                if (trig && op != OPC_NOP) begin
                    s_d.off = offset;
                    s_d.ptr = mbox_ptr;
                    unique case (op)
                        OPC_CREATE: begin
                            s_d.kind = ENG_CREATE;
                            s_d.base = trig_val;
                            s_d.st   = S_ENG;
                        end
                        OPC_FETCH: begin
                            s_d.kind = ENG_FETCH;
                            s_d.base = trig_val;
                            s_d.st   = S_RD_LO;
                        end
                        default: begin
                            s_d.kind = ENG_ERASE;
                            s_d.base = '0;
                            s_d.st   = S_RD_LO;
                        end
                    endcase
                end else if (walk) begin
                    s_d.off  = offset;
                    s_d.ptr  = mbox_ptr;
                    s_d.kind = ENG_NEXTID;
                    s_d.base = '0;
                    s_d.st   = S_RD_LO;
                end
            end
            S_RD_LO: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.id[WORD_W-1:0] = mem_rdata;
                    s_d.st = S_RD_HI;
                end
            end
            S_RD_HI: begin
                mem_req  = 1'b1;
                mem_addr = ptr_hi;
                if (mem_ack) begin
                    s_d.id[ID_W-1:WORD_W] = mem_rdata;
                    s_d.st = S_ENG;
                end
            end
            S_ENG: begin
                eng_req = 1'b1;
                if (eng_done) begin
                    s_d.stat = eng_status;
                    if (s_q.kind == ENG_NEXTID) begin
                        s_d.id = eng_rid;
                        s_d.st = S_WR_LO;
                    end else begin
                        s_d.st = S_IDLE;
                    end
                end
            end
            S_WR_LO: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) s_d.st = S_WR_HI;
            end
            default: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_hi;
                mem_wdata = s_q.id[ID_W-1:WORD_W];
                if (mem_ack) s_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= S_IDLE;
            s_q.kind <= ENG_CREATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st != S_IDLE);
    assign status     = s_q.stat;
    assign eng_op     = s_q.kind;
    assign eng_base   = s_q.base;
    assign eng_offset = s_q.off;
    assign eng_id     = s_q.id;
endmodule

// File: rtl/errstore_regfront.sv
module errstore_regfront
    import errstore_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IOA_W-1:0]   io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               eng_req,
    output logic [2:0]         eng_op,
    output logic [WORD_W-1:0]  eng_base,
    output logic [WORD_W-1:0]  eng_offset,
    output logic [ID_W-1:0]    eng_id,
    input  logic               eng_done,
    input  logic [STAT_W-1:0]  eng_status,
    input  logic [ID_W-1:0]    eng_rid,
    input  logic [WORD_W-1:0]  rec_count
);
    opc_e              op_w;
    logic [WORD_W-1:0] offset_w;
    logic [WORD_W-1:0] ptr_w;
    logic [WORD_W-1:0] trig_val_w;
    logic              trig_w;
    logic              walk_w;
    logic              busy_w;
    logic [STAT_W-1:0] status_w;

    errstore_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .busy      (busy_w),
        .status    (status_w),
        .rec_count (rec_count),
        .op        (op_w),
        .offset    (offset_w),
        .mbox_ptr  (ptr_w),
        .trig      (trig_w),
        .trig_val  (trig_val_w),
        .walk      (walk_w)
    );

    errstore_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op_w),
        .offset     (offset_w),
        .mbox_ptr   (ptr_w),
        .trig       (trig_w),
        .trig_val   (trig_val_w),
        .walk       (walk_w),
        .busy       (busy_w),
        .status     (status_w),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .eng_req    (eng_req),
        .eng_op     (eng_op),
        .eng_base   (eng_base),
        .eng_offset (eng_offset),
        .eng_id     (eng_id),
        .eng_done   (eng_done),
        .eng_status (eng_status),
        .eng_rid    (eng_rid)
    );
endmodule

// File: rtl/errstore_regfront_chk.sv
module errstore_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  io_addr,
    input logic        io_wr,
    input logic        busy,
    input logic [6:0]  status,
    input logic [1:0]  op,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        eng_req,
    input logic        eng_done,
    input logic [2:0]  eng_op,
    input logic [31:0] eng_base,
    input logic [31:0] eng_offset,
    input logic [63:0] eng_id
);
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && eng_req));

    p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_eng_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_base)
                                 && $stable(eng_offset) && $stable(eng_id));

    p_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == 4'hF && !busy && op != 2'd3 |=> busy);

    p_nop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == 4'hF && !busy && op == 2'd3 |=> !busy && !mem_req && !eng_req);

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_req && eng_done) |=> $stable(status));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_done && eng_op != 3'd4 |=> !busy);
endmodule

bind errstore_regfront errstore_regfront_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .busy       (busy_w),
    .status     (status_w),
    .op         (op_w),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .eng_req    (eng_req),
    .eng_done   (eng_done),
    .eng_op     (eng_op),
    .eng_base   (eng_base),
    .eng_offset (eng_offset),
    .eng_id     (eng_id)
);

// File: tb/errstore_regfront_tb.sv
module errstore_regfront_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        eng_req;
    logic [2:0]  eng_op;
    logic [31:0] eng_base, eng_offset;
    logic [63:0] eng_id;
    logic        eng_done = 1'b0;
    logic [6:0]  eng_status = '0;
    logic [63:0] eng_rid = '0;
    logic [31:0] rec_count = 32'h0000_0A05;

    int checks = 0, errors = 0, eng_lat = 2, eng_cnt = 0;
    bit finished = 0;

    typedef struct packed { logic [2:0] op; logic [31:0] base; logic [31:0] off; logic [63:0] id; } eng_rec_t;
    typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } mem_rec_t;
    eng_rec_t eng_log[$];
    mem_rec_t mem_log[$];
    logic [31:0] mem_model [int unsigned];

    // behavioural model of the port-visible state
    logic [1:0]  m_op;
    logic [31:0] m_off;
    logic        m_busy, m_walk;
    logic [6:0]  m_stat;
    int          m_acks;

    always #2 clk = ~clk;

    errstore_regfront dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_op <= '0; m_off <= '0; m_busy <= 0; m_walk <= 0; m_stat <= '0; m_acks <= 0;
        end else begin
            if (io_wr) begin
                if (io_addr == 4'h0) m_op <= io_wdata[1:0];
                if (io_addr >= 4'h4 && io_addr <= 4'h7) m_off[8*(io_addr-4) +: 8] <= io_wdata;
                if (io_addr == 4'hF && !m_busy && m_op != 2'd3) begin m_busy <= 1; m_walk <= 0; end
            end
            if (io_rd && io_addr == 4'h2 && !m_busy) begin m_busy <= 1; m_walk <= 1; m_acks <= 0; end
            if (eng_done) begin
                m_stat <= eng_status;
                if (!m_walk) m_busy <= 0;
            end
            if (mem_ack && m_walk && m_busy) begin
                m_acks <= m_acks + 1;
                if (m_acks == 3) m_busy <= 0;
            end
        end
        if (mem_req && mem_ack) begin
            if (mem_we) mem_model[mem_addr] = mem_wdata;
            mem_log.push_back({mem_we, mem_addr, mem_wdata});
        end
        if (eng_req && eng_done) eng_log.push_back({eng_op, eng_base, eng_offset, eng_id});
    end

    // responders, one time unit after the edge
    always begin
        @(posedge clk); #1;
        mem_ack = mem_req && !mem_ack;
        mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
        if (eng_req && !eng_done) begin
            if (eng_cnt >= eng_lat) begin eng_done = 1; eng_cnt = 0; end
            else eng_cnt++;
        end else begin
            eng_done = 0; eng_cnt = 0;
        end
    end

    // per-cycle comparison of the read byte (R10 busy/status, R2..R5 read map)
    always begin
        @(posedge clk); #3;
        if (rst_n) begin
            logic [7:0] e;
            case (io_addr)
                4'h0: e = {6'b0, m_op};
                4'h1: e = {m_busy, m_stat};
                4'h4, 4'h5, 4'h6, 4'h7: e = m_off[8*(io_addr-4) +: 8];
                4'h8, 4'h9, 4'hA, 4'hB: e = rec_count[8*(io_addr-8) +: 8];
                4'hC, 4'hD, 4'hE, 4'hF: e = 8'hFF;
                default: e = 8'h00;
            endcase
            chk(io_rdata === e, "R10 port model", io_rdata, e);
        end
    end

    task automatic wr8(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
        @(posedge clk); #1 io_wr = 0;
    endtask

    task automatic rd8(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); io_rd = 1; io_addr = a; #1 d = io_rdata;
        @(posedge clk); #1 io_rd = 0;
    endtask

    task automatic wr32(input logic [3:0] a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr8(a + 4'(b), v[8*b +: 8]);
    endtask

    task automatic wait_idle();
        logic [7:0] d;
        for (int i = 0; i < 200; i++) begin
            rd8(4'h1, d);
            if (!d[7]) break;
        end
    endtask

    task automatic clear_logs();
        eng_log.delete(); mem_log.delete();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        eng_rec_t er;
        mem_rec_t mr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd8(4'h1, d); chk(d == 8'h00, "R1 busy/status", d, 8'h00);
        rd8(4'h0, d); chk(d == 8'h00, "R1 op code", d, 8'h00);
        chk(!mem_req && !eng_req, "R1 no requests", {mem_req, eng_req}, 0);
        // R2 op register keeps two bits
        wr8(4'h0, 8'hFE); rd8(4'h0, d); chk(d == 8'h02, "R2 op readback", d, 8'h02);
        // R3 offset little-endian
        wr32(4'h4, 32'h1234_5678);
        rd8(4'h4, d); chk(d == 8'h78, "R3 offset byte0", d, 8'h78);
        rd8(4'h7, d); chk(d == 8'h12, "R3 offset byte3", d, 8'h12);
        // R4 count read and pointer write
        rd8(4'h8, d); chk(d == 8'h05, "R4 count byte0", d, 8'h05);
        rd8(4'h9, d); chk(d == 8'h0A, "R4 count byte1", d, 8'h0A);
        wr32(4'h8, 32'h0000_0100);
        // R5 constant ports, ignored writes
        wr8(4'h3, 8'h55); wr8(4'h1, 8'h7F);
        rd8(4'h3, d); chk(d == 8'h00, "R5 port3 zero", d, 8'h00);
        rd8(4'h1, d); chk(d == 8'h00, "R5 port1 write ignored", d, 8'h00);
        rd8(4'hC, d); chk(d == 8'hFF, "R5 launch port ones", d, 8'hFF);
        rd8(4'hF, d); chk(d == 8'hFF, "R5 launch port top ones", d, 8'hFF);

        // R6 create
        clear_logs(); eng_status = 7'h15;
        wr8(4'h0, 8'h00); wr32(4'hC, 32'h2000_0010);
        wait_idle();
        chk(eng_log.size() == 1, "R6 one engine request", eng_log.size(), 1);
        er = eng_log[0];
        chk(er.op == 3'd0 && er.base == 32'h2000_0010 && er.off == 32'h1234_5678, "R6 create fields",
            {er.op, er.base, er.off}, {3'd0, 32'h2000_0010, 32'h1234_5678});
        chk(mem_log.size() == 0, "R6 no memory", mem_log.size(), 0);
        rd8(4'h1, d); chk(d == 8'h15, "R10 status after create", d, 8'h15);

        // R7 fetch
        clear_logs(); eng_status = 7'h01;
        mem_model[32'h100] = 32'h89AB_CDEF; mem_model[32'h104] = 32'h0123_4567;
        wr8(4'h0, 8'h01); wr32(4'hC, 32'h0000_3000);
        wait_idle();
        chk(mem_log.size() == 2 && mem_log[0].addr == 32'h100 && mem_log[1].addr == 32'h104
            && !mem_log[0].we && !mem_log[1].we, "R7 mailbox read order", mem_log.size(), 2);
        er = eng_log[0];
        chk(er.op == 3'd1 && er.base == 32'h3000 && er.id == 64'h0123_4567_89AB_CDEF, "R7 fetch fields",
            er.id, 64'h0123_4567_89AB_CDEF);
        // R7 erase ignores launch value
        clear_logs();
        mem_model[32'h100] = 32'h0000_0042; mem_model[32'h104] = 32'h0;
        wr8(4'h0, 8'h02); wr32(4'hC, 32'hDEAD_BEEF);
        wait_idle();
        er = eng_log[0];
        chk(er.op == 3'd2 && er.base == 32'h0 && er.id == 64'h42, "R7 erase fields",
            {er.op, er.base}, {3'd2, 32'h0});

        // R8 no-op
        clear_logs();
        wr8(4'h0, 8'h03); wr32(4'hC, 32'h1111_1111);
        repeat (10) @(posedge clk);
        chk(eng_log.size() == 0 && mem_log.size() == 0, "R8 nop inert", eng_log.size() + mem_log.size(), 0);

        // R9 identifier walk
        clear_logs(); eng_rid = 64'h1111_2222_3333_4444; eng_status = 7'h02;
        mem_model[32'h100] = 32'hAAAA_0001; mem_model[32'h104] = 32'hBBBB_0002;
        rd8(4'h2, d); chk(d == 8'h00, "R5 port2 reads zero", d, 8'h00);
        wait_idle();
        chk(mem_log.size() == 4, "R9 four beats", mem_log.size(), 4);
        if (mem_log.size() == 4) begin
            mr = mem_log[2];
            chk(mr.we && mr.addr == 32'h100 && mr.data == 32'h3333_4444, "R9 low write-back", mr.data, 32'h3333_4444);
            mr = mem_log[3];
            chk(mr.we && mr.addr == 32'h104 && mr.data == 32'h1111_2222, "R9 high write-back", mr.data, 32'h1111_2222);
        end
        er = eng_log[0];
        chk(er.op == 3'd4 && er.id == 64'hBBBB_0002_AAAA_0001, "R9 lookup id", er.id, 64'hBBBB_0002_AAAA_0001);

        // R11 launches and walks ignored while busy
        clear_logs(); eng_lat = 8;
        wr8(4'h0, 8'h00); wr32(4'hC, 32'h0000_5000);
        wr8(4'hF, 8'h77); rd8(4'h2, d);
        wait_idle();
        chk(eng_log.size() == 1 && mem_log.size() == 0, "R11 busy ignores", eng_log.size(), 1);

        // R11 launch in the done cycle
        clear_logs(); eng_lat = 3;
        wr32(4'hC, 32'h0000_6000);
        do begin @(posedge clk); #2; end while (!eng_done);
        io_wr = 1; io_addr = 4'hF; io_wdata = 8'h00;
        @(posedge clk); #1 io_wr = 0;
        repeat (12) @(posedge clk);
        chk(eng_log.size() == 1, "R11 done-cycle launch ignored", eng_log.size(), 1);

        // R12 fields frozen while busy
        clear_logs(); eng_lat = 8;
        wr32(4'hC, 32'h0000_7000);
        wr8(4'h4, 8'h99); wr8(4'h0, 8'h01);
        wait_idle();
        er = eng_log[0];
        chk(er.op == 3'd0 && er.off == 32'h1234_5678 && er.base == 32'h7000, "R12 snapshot", er.off, 32'h1234_5678);
        rd8(4'h4, d); chk(d == 8'h99, "R3 offset rewritten", d, 8'h99);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule